// File: doc/BRIEF.md
# Peripheral Interrupt Mapping Controller

This block gathers up to 64 peripheral interrupt request lines and folds them onto the general-purpose event inputs of a core event controller. Every source can be enabled or blocked on its own, and its raw request is visible in a status word. A programmable 4-bit assignment field per source picks the core level that source drives. Any number of sources may share one level. The event line for each level is the OR of all enabled requests assigned to it.

The core's pending vector acts as the acknowledgement. When the pending bit of a level rises while requests on that level are still active, the block drops that level's event line for one cycle. The core then sees a fresh rising edge, so simultaneous assertions on a shared level are not lost. A separate wakeup path ORs each request with its wakeup-enable bit, without regard to the enable mask, and raises a wakeup request while the core reports idle or sleep.

Software reaches the registers through a simple word-addressed bus with a write strobe and combinational read data.

Top module: `pirq_mapper`

## Requirements
- R1: After reset, every enable, wakeup-enable and assignment register reads 0, `evt_out` is 0 and `wake_req` is 0.
- R2: Word addresses 0/1 hold the enable mask for sources 0–31/32–63, addresses 4/5 hold the wakeup enables for the same banks, and addresses 8–15 hold the assignment words; each reads back the value last written.
- R3: Addresses 2/3 return the request status for sources 0–31/32–63, one bit per source (bit n of the word is source 32*bank+n), one rising edge after the request changes; writes to these addresses change nothing.
- R4: `evt_out[i]` (core level 7+i) rises two clock edges after an enabled request assigned to that level appears; a request whose enable bit is 0 never reaches `evt_out`.
- R5: Source s is governed by assignment word 8+s/8, bits [4*(s%8)+3 : 4*(s%8)]; field value v selects core level v+7, i.e. `evt_out[v]` (0 gives level 7, 3 gives level 10, 6 gives level 13).
- R6: A field value of 9 to 15 routes its source to no level.
- R7: Sources sharing a level are ORed; the event stays high while any of them is still requesting.
- R8: A rising edge on `core_pend[7+i]` while level 7+i still has an active request drives `evt_out[i]` low for exactly one cycle, after which it returns high.
- R9: `wake_req` goes high one edge after `core_idle` is high while some request has its wakeup-enable bit set, whatever its enable mask holds, and stays low while `core_idle` is low.
- R10: Sources 49, 50 and 56–63 are reserved: they read 0 in status and never drive `evt_out` or `wake_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 64 | Peripheral request lines, one per source |
| bus_addr | input | 5 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| core_pend | input | 16 | Core pending vector, bit L is level L |
| core_idle | input | 1 | Core is idle or asleep |
| evt_out | output | 9 | Event lines for levels 7 to 15 |
| wake_req | output | 1 | Wakeup request |

## Verification
The bench targets the field decode at the edges of the assignment words. A design that shifts the fields by one would drive level 10 from the wrong source, or would let an out-of-range value alias onto a real level. A shared level is released one source at a time: an AND reduction, or a design that latched only the first source, would drop the event early. The acknowledgement is raised while a request is held: a design that ignores it would keep the line flat and hide the new edge, and one that keys on the pending level instead of its edge would hold the line low. The wakeup is checked on a blocked source and with the core busy, and the reserved sources are driven with every enable set.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   localparam int unsigned DEF_NUM_SRC    = 64;
   localparam int unsigned DEF_BANK_W     = 32;
   localparam int unsigned DEF_FIELD_W    = 4;
   localparam int unsigned DEF_NUM_LEVELS = 9;
   localparam int unsigned DEF_LEVEL_BASE = 7;
   localparam int unsigned DEF_ADDR_W     = 5;
   localparam int unsigned DEF_ASG_BASE   = 8;
   localparam logic [63:0] DEF_RSVD       = 64'hFF06_0000_0000_0000;

   function automatic logic addr_hit(input logic [7:0] addr, input int unsigned word);
      return addr == 8'(word);
   endfunction
endpackage

// File: rtl/pirq_regs.sv
module pirq_regs
   import pirq_pkg::*;
#(
   parameter int unsigned NUM_SRC  = DEF_NUM_SRC,
   parameter int unsigned BANK_W   = DEF_BANK_W,
   parameter int unsigned FIELD_W  = DEF_FIELD_W,
   parameter int unsigned ADDR_W   = DEF_ADDR_W,
   parameter int unsigned ASG_BASE = DEF_ASG_BASE,
   parameter logic [NUM_SRC-1:0] RSVD = NUM_SRC'(DEF_RSVD)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SRC-1:0]         irq_in,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic                       bus_we,
   input  logic [BANK_W-1:0]          bus_wdata,
   output logic [BANK_W-1:0]          bus_rdata,
   output logic [NUM_SRC-1:0]         req_o,
   output logic [NUM_SRC-1:0]         mask_o,
   output logic [NUM_SRC-1:0]         wake_o,
   output logic [NUM_SRC*FIELD_W-1:0] asg_o
);
   localparam int unsigned NUM_BANKS = NUM_SRC / BANK_W;
   localparam int unsigned PER_WORD  = BANK_W / FIELD_W;
   localparam int unsigned NUM_ASG   = NUM_SRC / PER_WORD;
   localparam int unsigned STAT_BASE = NUM_BANKS;
   localparam int unsigned WAKE_BASE = 2 * NUM_BANKS;

   logic [NUM_SRC-1:0] req_q;
   logic [BANK_W-1:0]  mask_q [NUM_BANKS];
   logic [BANK_W-1:0]  wake_q [NUM_BANKS];
   logic [BANK_W-1:0]  asg_q  [NUM_ASG];
   logic [7:0]         addr8;

   assign addr8 = 8'(bus_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= irq_in & ~RSVD;
   end
   assign req_o = req_q;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q[b] <= '0;
            wake_q[b] <= '0;
         end else if (bus_we) begin
            if (addr_hit(addr8, b))             mask_q[b] <= bus_wdata;
            if (addr_hit(addr8, WAKE_BASE + b)) wake_q[b] <= bus_wdata;
         end
      end
      assign mask_o[b*BANK_W +: BANK_W] = mask_q[b];
      assign wake_o[b*BANK_W +: BANK_W] = wake_q[b];
   end

   for (genvar a = 0; a < NUM_ASG; a++) begin : g_asg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                     asg_q[a] <= '0;
         else if (bus_we && addr_hit(addr8, ASG_BASE + a)) asg_q[a] <= bus_wdata;
      end
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_fld
      assign asg_o[s*FIELD_W +: FIELD_W] = asg_q[s / PER_WORD][(s % PER_WORD)*FIELD_W +: FIELD_W];
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (addr_hit(addr8, b))             bus_rdata = mask_q[b];
         if (addr_hit(addr8, STAT_BASE + b)) bus_rdata = req_q[b*BANK_W +: BANK_W];
         if (addr_hit(addr8, WAKE_BASE + b)) bus_rdata = wake_q[b];
      end
      for (int a = 0; a < NUM_ASG; a++) begin
         if (addr_hit(addr8, ASG_BASE + a)) bus_rdata = asg_q[a];
      end
   end
endmodule

// File: rtl/pirq_route.sv
module pirq_route #(
   parameter int unsigned NUM_SRC    = 64,
   parameter int unsigned FIELD_W    = 4,
   parameter int unsigned NUM_LEVELS = 9
) (
   input  logic [NUM_SRC-1:0]         req,
   input  logic [NUM_SRC-1:0]         mask,
   input  logic [NUM_SRC*FIELD_W-1:0] asg,
   output logic [NUM_LEVELS-1:0]      level_raw
);
   logic [NUM_SRC-1:0] live;
   assign live = req & mask;

   for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl
      logic [NUM_SRC-1:0] sel;
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         assign sel[s] = (asg[s*FIELD_W +: FIELD_W] == FIELD_W'(i));
      end
      assign level_raw[i] = |(live & sel);
   end
endmodule

// File: rtl/pirq_ack.sv
module pirq_ack #(
   parameter int unsigned NUM_LEVELS = 9
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LEVELS-1:0] level_raw,
   input  logic [NUM_LEVELS-1:0] pend,
   output logic [NUM_LEVELS-1:0] evt
);
   logic [NUM_LEVELS-1:0] pend_q;
   logic [NUM_LEVELS-1:0] evt_q;
   logic [NUM_LEVELS-1:0] ack_edge;

   assign ack_edge = pend & ~pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         evt_q  <= '0;
      end else begin
         pend_q <= pend;
         evt_q  <= level_raw & ~ack_edge;
      end
   end
   assign evt = evt_q;
endmodule

// File: rtl/pirq_mapper.sv
module pirq_mapper
   import pirq_pkg::*;
#(
   parameter int unsigned NUM_SRC    = DEF_NUM_SRC,
   parameter int unsigned BANK_W     = DEF_BANK_W,
   parameter int unsigned FIELD_W    = DEF_FIELD_W,
   parameter int unsigned NUM_LEVELS = DEF_NUM_LEVELS,
   parameter int unsigned LEVEL_BASE = DEF_LEVEL_BASE,
   parameter int unsigned ADDR_W     = DEF_ADDR_W,
   parameter int unsigned ASG_BASE   = DEF_ASG_BASE,
   parameter logic [NUM_SRC-1:0] RSVD = NUM_SRC'(DEF_RSVD),
   localparam int unsigned PEND_W    = LEVEL_BASE + NUM_LEVELS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_SRC-1:0]    irq_in,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_we,
   input  logic [BANK_W-1:0]     bus_wdata,
   output logic [BANK_W-1:0]     bus_rdata,
   input  logic [PEND_W-1:0]     core_pend,
   input  logic                  core_idle,
   output logic [NUM_LEVELS-1:0] evt_out,
   output logic                  wake_req
);
   localparam int unsigned NUM_ASG = NUM_SRC * FIELD_W / BANK_W;

   if (NUM_SRC % BANK_W != 0) begin : g_chk_bank
      $error("NUM_SRC must be a multiple of BANK_W");
   end
   if (BANK_W % FIELD_W != 0) begin : g_chk_field
      $error("BANK_W must hold a whole number of fields");
   end
   if (NUM_LEVELS > (1 << FIELD_W)) begin : g_chk_lvl
      $error("NUM_LEVELS exceeds field range");
   end
   if (LEVEL_BASE < 1) begin : g_chk_base
      $error("LEVEL_BASE must be at least 1");
   end
   if (ASG_BASE < 3 * (NUM_SRC / BANK_W) || ASG_BASE + NUM_ASG > (1 << ADDR_W)) begin : g_chk_map
      $error("assignment words do not fit the address map");
   end

   logic [NUM_SRC-1:0]         req_q;
   logic [NUM_SRC-1:0]         mask_vec;
   logic [NUM_SRC-1:0]         wake_vec;
   logic [NUM_SRC*FIELD_W-1:0] asg_vec;
   logic [NUM_LEVELS-1:0]      level_raw;
   logic                       wake_q;
   logic                       pend_unused;

   assign pend_unused = ^core_pend[LEVEL_BASE-1:0];

   pirq_regs #(
      .NUM_SRC(NUM_SRC), .BANK_W(BANK_W), .FIELD_W(FIELD_W),
      .ADDR_W(ADDR_W), .ASG_BASE(ASG_BASE), .RSVD(RSVD)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .req_o(req_q), .mask_o(mask_vec), .wake_o(wake_vec), .asg_o(asg_vec)
   );

   pirq_route #(
      .NUM_SRC(NUM_SRC), .FIELD_W(FIELD_W), .NUM_LEVELS(NUM_LEVELS)
   ) u_route (
      .req(req_q), .mask(mask_vec), .asg(asg_vec), .level_raw(level_raw)
   );

   pirq_ack #(
      .NUM_LEVELS(NUM_LEVELS)
   ) u_ack (
      .clk(clk), .rst_n(rst_n), .level_raw(level_raw),
      .pend(core_pend[LEVEL_BASE +: NUM_LEVELS]), .evt(evt_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_q <= 1'b0;
      else        wake_q <= core_idle & (|(req_q & wake_vec));
   end
   assign wake_req = wake_q;
endmodule

// File: rtl/pirq_mapper_chk.sv
module pirq_mapper_chk #(
   parameter int unsigned NUM_SRC    = 64,
   parameter int unsigned NUM_LEVELS = 9,
   parameter int unsigned LEVEL_BASE = 7
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             core_idle,
   input logic [LEVEL_BASE+NUM_LEVELS-1:0] core_pend,
   input logic [NUM_LEVELS-1:0]            evt_out,
   input logic                             wake_req,
   input logic [NUM_LEVELS-1:0]            level_raw,
   input logic [NUM_SRC-1:0]               req_q,
   input logic [NUM_SRC-1:0]               mask_vec,
   input logic [NUM_SRC-1:0]               wake_vec
);
   p_evt_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_out != '0) |-> $past(|(req_q & mask_vec)));

   p_wake_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> $past(core_idle));

   p_wake_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> $past(|(req_q & wake_vec)));

   for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_lvl
      p_evt_routed_r7: assert property (@(posedge clk) disable iff (!rst_n)
         evt_out[i] |-> $past(level_raw[i]));

      p_ack_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(core_pend[LEVEL_BASE+i]) |=> !evt_out[i]);
   end
endmodule

bind pirq_mapper pirq_mapper_chk #(
   .NUM_SRC(NUM_SRC), .NUM_LEVELS(NUM_LEVELS), .LEVEL_BASE(LEVEL_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .core_idle(core_idle), .core_pend(core_pend),
   .evt_out(evt_out), .wake_req(wake_req), .level_raw(level_raw),
   .req_q(req_q), .mask_vec(mask_vec), .wake_vec(wake_vec)
);

// File: tb/pirq_mapper_tb.sv
module pirq_mapper_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] irq_in = '0;
   logic [4:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] core_pend = '0;
   logic        core_idle = 1'b0;
   logic [8:0]  evt_out;
   logic        wake_req;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   pirq_mapper u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .core_pend(core_pend), .core_idle(core_idle), .evt_out(evt_out), .wake_req(wake_req)
   );

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(req, $sformatf("read addr %0d", a), 64'(bus_rdata), 64'(exp));
   endtask

   task automatic drive_irq(input logic [63:0] v, input int edges);
      @(negedge clk);
      irq_in = v;
      repeat (edges) @(negedge clk);
   endtask

   task automatic t_reset;
      check("R1", "evt_out after reset", 64'(evt_out), 64'h0);
      check("R1", "wake_req after reset", 64'(wake_req), 64'h0);
      for (int a = 0; a < 16; a++) begin
         if (a != 2 && a != 3 && a != 6 && a != 7) rd_chk("R1", 5'(a), 32'h0);
      end
   endtask

   task automatic t_regs;
      wr(5'd0, 32'hA5A5_0F0F);
      wr(5'd5, 32'h1234_5678);
      wr(5'd13, 32'h8765_4321);
      rd_chk("R2", 5'd0, 32'hA5A5_0F0F);
      rd_chk("R2", 5'd5, 32'h1234_5678);
      rd_chk("R2", 5'd13, 32'h8765_4321);
      wr(5'd0, 32'h0);
      wr(5'd5, 32'h0);
      rd_chk("R2", 5'd0, 32'h0);
   endtask

   task automatic t_status;
      drive_irq(64'h0000_0011_8000_0001, 1);
      rd_chk("R3", 5'd2, 32'h8000_0001);
      rd_chk("R3", 5'd3, 32'h0000_0011);
      wr(5'd2, 32'hFFFF_FFFF);
      wr(5'd3, 32'hFFFF_FFFF);
      rd_chk("R3", 5'd2, 32'h8000_0001);
      rd_chk("R3", 5'd3, 32'h0000_0011);
      rd_chk("R3", 5'd0, 32'h0);
      check("R4", "evt with all masked", 64'(evt_out), 64'h0);
      drive_irq(64'h0, 2);
   endtask

   task automatic t_route;
      wr(5'd13, 32'h0603_3090);
      wr(5'd14, 32'h0003_3000);
      wr(5'd1, 32'h0018_4B00);
      drive_irq(64'h1 << 43, 2);
      check("R5", "src43 value3 -> level10", 64'(evt_out), 64'h008);
      drive_irq(64'h1 << 40, 2);
      check("R5", "src40 value0 -> level7", 64'(evt_out), 64'h001);
      drive_irq(64'h1 << 46, 2);
      check("R5", "src46 value6 -> level13", 64'(evt_out), 64'h040);
      drive_irq(64'h1 << 44, 2);
      check("R4", "masked src44 blocked", 64'(evt_out), 64'h000);
      drive_irq(64'h0, 2);
   endtask

   task automatic t_range;
      drive_irq(64'h1 << 41, 2);
      check("R6", "value9 routes nowhere", 64'(evt_out), 64'h000);
      drive_irq(64'h0, 2);
   endtask

   task automatic t_share;
      drive_irq((64'h1 << 51) | (64'h1 << 52), 2);
      check("R7", "two sources share level10", 64'(evt_out), 64'h008);
      drive_irq(64'h1 << 52, 2);
      check("R7", "one source left", 64'(evt_out), 64'h008);
      drive_irq(64'h0, 2);
      check("R7", "all released", 64'(evt_out), 64'h000);
   endtask

   task automatic t_ack;
      drive_irq(64'h1 << 43, 2);
      check("R8", "level10 up before ack", 64'(evt_out), 64'h008);
      core_pend = 16'h0400;
      @(negedge clk);
      check("R8", "gap after ack edge", 64'(evt_out), 64'h000);
      @(negedge clk);
      check("R8", "re-asserted after gap", 64'(evt_out), 64'h008);
      @(negedge clk);
      check("R8", "held while pending stays", 64'(evt_out), 64'h008);
      core_pend = 16'h0;
      drive_irq(64'h0, 2);
   endtask

   task automatic t_wake;
      wr(5'd5, 32'h0000_1000);
      core_idle = 1'b0;
      drive_irq(64'h1 << 44, 2);
      check("R9", "busy core no wake", 64'(wake_req), 64'h0);
      core_idle = 1'b1;
      @(negedge clk);
      check("R9", "idle wake on masked src", 64'(wake_req), 64'h1);
      check("R9", "masked src no event", 64'(evt_out), 64'h0);
      drive_irq(64'h1 << 43, 2);
      check("R9", "no wake without enable", 64'(wake_req), 64'h0);
      drive_irq(64'h0, 2);
      core_idle = 1'b0;
   endtask

   task automatic t_rsvd;
      logic [63:0] rs;
      rs = 64'hFF06_0000_0000_0000;
      wr(5'd1, 32'hFFFF_FFFF);
      wr(5'd5, 32'hFFFF_FFFF);
      wr(5'd14, 32'h0);
      wr(5'd15, 32'h0);
      core_idle = 1'b1;
      drive_irq(rs, 2);
      rd_chk("R10", 5'd3, 32'h0);
      check("R10", "reserved no event", 64'(evt_out), 64'h0);
      check("R10", "reserved no wake", 64'(wake_req), 64'h0);
      drive_irq(64'h1 << 48, 2);
      check("R10", "neighbour src48 live", 64'(evt_out), 64'h001);
      drive_irq(64'h0, 2);
      core_idle = 1'b0;
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog (all R) actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_status();
      t_route();
      t_range();
      t_share();
      t_ack();
      t_wake();
      t_rsvd();
      finish_run();
   end
endmodule